// File: doc/BRIEF.md
# Store Coalescing Buffer

The block gathers a run of small stores into one memory write. Each store carries an address, a size code, up to 16 bytes of data, an access kind and an exclusive flag. The first store into an empty buffer fixes the base address and attributes. Each later store must continue the byte run exactly where the held bytes end and must carry the same attributes. Its bytes are packed directly above the bytes already held.

A flush command turns the held run into a single request on the memory port. The request gives the base address, the total size, the packed data and a write kind. An exclusive flush also returns the pass/fail bit that memory reports. A store or flush that breaks a rule is still acknowledged, but it leaves the buffer untouched and sets a sticky error output.

All three streams use valid/ready. An item transfers on a rising edge where both valid and ready are high. Store and flush inputs may be held valid for any number of cycles. While a flush request is waiting on the memory port, both input readies stay low. A flush offered in the same cycle as a store is taken first, and the store waits. Once a memory request is raised, it keeps its contents until memory accepts it.

Top module: `store_coalescer`

## Requirements
- R1: After reset `st_ready` and `fl_ready` are high, and `mem_valid`, `xres_valid` and `err` are low.
- R2: A store into an empty buffer loads its address, kind, exclusive flag and size. Size code c means 2^c bytes, and codes 0 to 4 are legal. Only the low 2^c bytes of `st_data` are kept, and the bytes above them are sent as zero.
- R3: A later store merges only when its kind and exclusive flag match the held ones and its address equals the base address plus the held byte count. Its bytes land directly above the held bytes.
- R4: A store that would raise the held total above 16 bytes is dropped and sets `err`.
- R5: A store with a mismatched kind, a mismatched exclusive flag, a non-adjacent address, a size code above 4 or a kind code above 4 is dropped and sets `err`. The held contents stay unchanged.
- R6: A flush is issued only when the held total is 1, 2, 4, 8 or 16 bytes. `mem_size` then carries log2 of that total. A flush of any other total, including zero, is dropped, sets `err` and leaves the contents unchanged.
- R7: Kind codes are normal=0, streaming=1, unprivileged=2, ordered=3 and atomic=4. `mem_wkind` is 0 (plain) for a non-exclusive normal, streaming or unprivileged run and 1 (release) for a non-exclusive ordered run. It is 2 (exclusive) for an exclusive atomic run and 3 (exclusive release) for an exclusive ordered run.
- R8: A flush whose `fl_excl` differs from the held exclusive flag is dropped and sets `err`. So are a non-exclusive flush of an atomic run and an exclusive flush of a normal, streaming or unprivileged run.
- R9: While `mem_valid` is high, `st_ready` and `fl_ready` are low, and the memory request fields hold steady until `mem_ready`.
- R10: After the memory handshake the buffer is empty, and the next store starts a new run at its own address.
- R11: One cycle after an exclusive memory handshake, `xres_valid` pulses for one cycle with `xres_pass` equal to `mem_pass` at the handshake. Non-exclusive writes give no pulse.
- R12: When `fl_valid` is high, `st_ready` is low, so a flush is taken before a store offered in the same cycle.
- R13: `err` stays high once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken |
| st_addr | input | 64 | Store byte address |
| st_size | input | 3 | Store size code, 2^code bytes |
| st_data | input | 128 | Store data, low bytes significant |
| st_kind | input | 3 | Access kind code |
| st_excl | input | 1 | Exclusive flag |
| fl_valid | input | 1 | Flush command offered |
| fl_ready | output | 1 | Flush can be taken |
| fl_excl | input | 1 | Flush is exclusive |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_addr | output | 64 | Write base address |
| mem_size | output | 3 | Write size code |
| mem_data | output | 128 | Packed write data |
| mem_wkind | output | 2 | Write kind |
| mem_pass | input | 1 | Exclusive result, sampled at handshake |
| xres_valid | output | 1 | Exclusive result pulse |
| xres_pass | output | 1 | Exclusive result value |
| err | output | 1 | Sticky rule-violation flag |

## Verification
The bench targets the points where a run can be corrupted. These are a store landing one byte past the held end, a total that would spill past 16 bytes, and flushes of 3 bytes or of an empty buffer. A design that checked adjacency or the cap loosely would let a bad store alter the run, and the write issued afterwards would then show a wrong size or wrong data. A design that ignored the power-of-two rule would emit a write the scoreboard never expected. Mismatched exclusive flags and kinds must change `err` without producing a write. A store offered in the same cycle as a flush would be merged into the flushed run, or lost, if the priority were wrong. Random legal runs check the byte placement, the size and the write kind under memory back-pressure.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam logic [2:0] ACC_NORMAL  = 3'd0;
  localparam logic [2:0] ACC_STREAM  = 3'd1;
  localparam logic [2:0] ACC_UNPRIV  = 3'd2;
  localparam logic [2:0] ACC_ORDERED = 3'd3;
  localparam logic [2:0] ACC_ATOMIC  = 3'd4;

  typedef enum logic [1:0] {
    WK_PLAIN    = 2'd0,
    WK_RELEASE  = 2'd1,
    WK_EXCL     = 2'd2,
    WK_EXCL_REL = 2'd3
  } wkind_e;

  typedef enum logic {
    IS_IDLE = 1'b0,
    IS_BUSY = 1'b1
  } issue_e;
endpackage

// File: rtl/stc_accum.sv
module stc_accum
  import stc_pkg::*;
#(
  parameter int AW        = 64,
  parameter int MAX_BYTES = 16,
  localparam int DW    = MAX_BYTES * 8,
  localparam int LOGB  = $clog2(MAX_BYTES),
  localparam int CODEW = $clog2(LOGB + 1),
  localparam int CNTW  = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             clear,
  input  logic [AW-1:0]    in_addr,
  input  logic [CODEW-1:0] in_code,
  input  logic [DW-1:0]    in_data,
  input  logic [2:0]       in_kind,
  input  logic             in_excl,
  output logic             in_bad,
  output logic [AW-1:0]    q_addr,
  output logic [CNTW-1:0]  q_cnt,
  output logic [DW-1:0]    q_data,
  output logic [2:0]       q_kind,
  output logic             q_excl
);
  localparam logic [CNTW:0] ONE_B = (CNTW + 1)'(1);
  localparam logic [CNTW:0] CAP   = (CNTW + 1)'(MAX_BYTES);

  logic [CNTW:0] in_bytes;
  logic [CNTW:0] total;
  logic          code_ok, kind_ok, attr_ok, adj_ok, fit_ok, empty;
  logic [DW-1:0] lane_data;
  logic [DW-1:0] merged;

  always_comb begin
    code_ok  = (int'(in_code) <= LOGB);
    in_bytes = code_ok ? (ONE_B << in_code) : '0;
    empty    = (q_cnt == '0);
    total    = {1'b0, q_cnt} + in_bytes;
    fit_ok   = (total <= CAP);
    kind_ok  = (in_kind <= ACC_ATOMIC);
    attr_ok  = empty || ((in_kind == q_kind) && (in_excl == q_excl));
    adj_ok   = empty || (in_addr == (q_addr + AW'(q_cnt)));
    in_bad   = !(code_ok && kind_ok && attr_ok && adj_ok && fit_ok);
  end

  // keep only the bytes the size code covers
  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_lane
    assign lane_data[b*8 +: 8] = (in_bytes > (CNTW + 1)'(b)) ? in_data[b*8 +: 8] : 8'h00;
  end

  // new bytes go directly above the held ones
  assign merged = q_data | (lane_data << {q_cnt, 3'b000});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_addr <= '0;
      q_cnt  <= '0;
      q_data <= '0;
      q_kind <= ACC_NORMAL;
      q_excl <= 1'b0;
    end else if (clear) begin
      q_cnt  <= '0;
      q_data <= '0;
    end else if (take && !in_bad) begin
      if (empty) begin
        q_addr <= in_addr;
        q_kind <= in_kind;
        q_excl <= in_excl;
      end
      q_cnt  <= total[CNTW-1:0];
      q_data <= merged;
    end
  end
endmodule

// File: rtl/stc_flush_rules.sv
module stc_flush_rules
  import stc_pkg::*;
#(
  parameter int MAX_BYTES = 16,
  localparam int LOGB  = $clog2(MAX_BYTES),
  localparam int CODEW = $clog2(LOGB + 1),
  localparam int CNTW  = $clog2(MAX_BYTES + 1)
) (
  input  logic [CNTW-1:0]  q_cnt,
  input  logic [2:0]       q_kind,
  input  logic             q_excl,
  input  logic             req_excl,
  output logic             ok,
  output wkind_e           wkind,
  output logic [CODEW-1:0] size_code
);
  logic pow2, kind_legal;

  always_comb begin
    pow2 = (q_cnt != '0) && ((q_cnt & (q_cnt - CNTW'(1))) == '0);
    if (req_excl) kind_legal = (q_kind == ACC_ATOMIC) || (q_kind == ACC_ORDERED);
    else          kind_legal = q_kind inside {ACC_NORMAL, ACC_STREAM, ACC_UNPRIV, ACC_ORDERED};
    ok = pow2 && (q_excl == req_excl) && kind_legal;

    if (q_excl) wkind = (q_kind == ACC_ORDERED) ? WK_EXCL_REL : WK_EXCL;
    else        wkind = (q_kind == ACC_ORDERED) ? WK_RELEASE  : WK_PLAIN;

    size_code = '0;
    for (int i = 0; i <= LOGB; i++) begin
      if (q_cnt == CNTW'(1 << i)) size_code = CODEW'(i);
    end
  end
endmodule

// File: rtl/stc_issue.sv
module stc_issue
  import stc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic mem_ready,
  input  logic mem_pass,
  input  logic is_excl,
  output logic busy,
  output logic done,
  output logic xres_valid,
  output logic xres_pass
);
  issue_e state;

  assign busy = (state == IS_BUSY);
  assign done = busy && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= IS_IDLE;
      xres_valid <= 1'b0;
      xres_pass  <= 1'b0;
    end else begin
      case (state)
        IS_IDLE: if (launch) state <= IS_BUSY;
        IS_BUSY: if (mem_ready) state <= IS_IDLE;
        default: state <= IS_IDLE;
      endcase
      xres_valid <= done && is_excl;
      xres_pass  <= done && is_excl && mem_pass;
    end
  end
endmodule

// File: rtl/store_coalescer.sv
module store_coalescer
  import stc_pkg::*;
#(
  parameter int AW        = 64,
  parameter int MAX_BYTES = 16,
  localparam int DW    = MAX_BYTES * 8,
  localparam int LOGB  = $clog2(MAX_BYTES),
  localparam int CODEW = $clog2(LOGB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  output logic             st_ready,
  input  logic [AW-1:0]    st_addr,
  input  logic [CODEW-1:0] st_size,
  input  logic [DW-1:0]    st_data,
  input  logic [2:0]       st_kind,
  input  logic             st_excl,
  input  logic             fl_valid,
  output logic             fl_ready,
  input  logic             fl_excl,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [AW-1:0]    mem_addr,
  output logic [CODEW-1:0] mem_size,
  output logic [DW-1:0]    mem_data,
  output logic [1:0]       mem_wkind,
  input  logic             mem_pass,
  output logic             xres_valid,
  output logic             xres_pass,
  output logic             err
);
  localparam int CNTW = $clog2(MAX_BYTES + 1);

  logic            busy, done, st_take, fl_take, st_bad, fl_ok;
  logic [CNTW-1:0] q_cnt;
  logic [2:0]      q_kind;
  logic            q_excl;
  wkind_e          wk;

  assign fl_ready = !busy;
  assign st_ready = !busy && !fl_valid;
  assign st_take  = st_valid && st_ready;
  assign fl_take  = fl_valid && fl_ready;

  stc_accum #(.AW(AW), .MAX_BYTES(MAX_BYTES)) u_accum (
    .clk(clk), .rst_n(rst_n), .take(st_take), .clear(done),
    .in_addr(st_addr), .in_code(st_size), .in_data(st_data),
    .in_kind(st_kind), .in_excl(st_excl), .in_bad(st_bad),
    .q_addr(mem_addr), .q_cnt(q_cnt), .q_data(mem_data),
    .q_kind(q_kind), .q_excl(q_excl)
  );

  stc_flush_rules #(.MAX_BYTES(MAX_BYTES)) u_rules (
    .q_cnt(q_cnt), .q_kind(q_kind), .q_excl(q_excl), .req_excl(fl_excl),
    .ok(fl_ok), .wkind(wk), .size_code(mem_size)
  );

  stc_issue u_issue (
    .clk(clk), .rst_n(rst_n), .launch(fl_take && fl_ok),
    .mem_ready(mem_ready), .mem_pass(mem_pass), .is_excl(q_excl),
    .busy(busy), .done(done), .xres_valid(xres_valid), .xres_pass(xres_pass)
  );

  assign mem_valid = busy;
  assign mem_wkind = wk;

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else if ((st_take && st_bad) || (fl_take && !fl_ok)) err <= 1'b1;
  end
endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
  parameter int AW        = 64,
  parameter int MAX_BYTES = 16,
  localparam int DW    = MAX_BYTES * 8,
  localparam int LOGB  = $clog2(MAX_BYTES),
  localparam int CODEW = $clog2(LOGB + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_valid,
  input logic             st_ready,
  input logic             fl_valid,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [AW-1:0]    mem_addr,
  input logic [CODEW-1:0] mem_size,
  input logic [DW-1:0]    mem_data,
  input logic [1:0]       mem_wkind,
  input logic             xres_valid,
  input logic             err
);
  logic [DW-1:0] keep_mask;
  always_comb begin
    if (int'(mem_size) >= LOGB) keep_mask = '1;
    else keep_mask = ({{(DW-1){1'b0}}, 1'b1} << (8 << mem_size)) - 1'b1;
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)
      && $stable(mem_size) && $stable(mem_wkind));

  assert_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_xres_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xres_valid |-> $past(mem_valid && mem_ready && mem_wkind[1]));

  assert_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_data & ~keep_mask) == '0);

  assert_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> int'(mem_size) <= LOGB);

  assert_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> !mem_valid);

  assert_prio_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && st_valid |-> !st_ready);
endmodule

bind store_coalescer stc_checker #(.AW(AW), .MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .fl_valid(fl_valid), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_size(mem_size), .mem_data(mem_data),
  .mem_wkind(mem_wkind), .xres_valid(xres_valid), .err(err)
);

// File: tb/store_coalescer_bench.sv
`timescale 1ns/1ps
module store_coalescer_bench;
  import stc_pkg::*;

  logic clk = 0, rst_n = 0;
  logic st_valid = 0, st_excl = 0, fl_valid = 0, fl_excl = 0, mem_ready = 0, mem_pass = 0;
  logic [63:0] st_addr = 0;
  logic [2:0] st_size = 0, st_kind = 0;
  logic [127:0] st_data = 0;
  logic st_ready, fl_ready, mem_valid, xres_valid, xres_pass, err;
  logic [63:0] mem_addr;
  logic [2:0] mem_size;
  logic [127:0] mem_data;
  logic [1:0] mem_wkind;

  store_coalescer u_store_coalescer (.*);

  always #4 clk = ~clk;

  typedef struct { logic [63:0] a; logic [2:0] sz; logic [127:0] d; logic [1:0] wk; } exp_t;
  exp_t sbq[$];
  int nchk = 0, nfail = 0;
  bit x_pend = 0, x_exp = 0, finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] bmask(input int c);
    return (c >= 4) ? '1 : ((128'h1 << (8 << c)) - 128'h1);
  endfunction

  function automatic logic [1:0] wk_of(input logic [2:0] k, input bit ex);
    if (ex) return (k == ACC_ORDERED) ? 2'd3 : 2'd2;
    return (k == ACC_ORDERED) ? 2'd1 : 2'd0;
  endfunction

  task automatic push_exp(input logic [63:0] a, input logic [2:0] sz, input logic [127:0] d, input logic [1:0] wk);
    exp_t e;
    e.a = a; e.sz = sz; e.d = d; e.wk = wk;
    sbq.push_back(e);
  endtask

  task automatic put_store(input logic [63:0] a, input logic [2:0] c, input logic [127:0] d,
                           input logic [2:0] k, input bit ex);
    @(negedge clk);
    while (!st_ready) @(negedge clk);
    st_addr = a; st_size = c; st_data = d; st_kind = k; st_excl = ex; st_valid = 1;
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic put_flush(input bit ex);
    @(negedge clk);
    while (!fl_ready) @(negedge clk);
    fl_excl = ex; fl_valid = 1;
    @(negedge clk);
    fl_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (mem_valid || sbq.size() != 0 || x_pend);
  endtask

  task automatic do_reset();
    wait_idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // monitor: random back-pressure, scoreboard compare at each handshake
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        x_pend = 0;
      end else begin
        bit r;
        exp_t e;
        if (x_pend) begin
          chk(xres_valid && (xres_pass == x_exp), "R11 exclusive result",
              {xres_valid, xres_pass}, {1'b1, x_exp});
          x_pend = 0;
        end else if (xres_valid) begin
          chk(0, "R11 unexpected result pulse", 1, 0);
        end
        if (mem_valid) chk(!st_ready && !fl_ready, "R9 inputs stalled", {st_ready, fl_ready}, 0);
        r = 1'($urandom_range(0, 1));
        mem_pass = 1'($urandom_range(0, 1));
        mem_ready = r;
        if (mem_valid && r) begin
          if (sbq.size() == 0) begin
            chk(0, "R6 write not expected", mem_addr, 0);
          end else begin
            e = sbq.pop_front();
            chk(mem_addr == e.a, "R2 base address", mem_addr, e.a);
            chk(mem_size == e.sz, "R6 size code", mem_size, e.sz);
            chk(mem_data == e.d, "R3 packed data", mem_data, e.d);
            chk(mem_wkind == e.wk, "R7 write kind", mem_wkind, e.wk);
            if (e.wk[1]) begin x_pend = 1; x_exp = mem_pass; end
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(st_ready == 1, "R1 st_ready", st_ready, 1);
    chk(fl_ready == 1, "R1 fl_ready", fl_ready, 1);
    chk(mem_valid == 0, "R1 mem_valid", mem_valid, 0);
    chk(xres_valid == 0, "R1 xres_valid", xres_valid, 0);
    chk(err == 0, "R1 err", err, 0);

    // R2 R3: two 4-byte stores with junk above the valid bytes
    put_store(64'h1000, 3'd2, {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'hAABBCCDD}, ACC_NORMAL, 0);
    put_store(64'h1004, 3'd2, {96'h1234_5678_9ABC_DEF0_0F0F_0F0F, 32'h11223344}, ACC_NORMAL, 0);
    push_exp(64'h1000, 3'd3, 128'h11223344_AABBCCDD, 2'd0);
    put_flush(0);

    // R7 ordered single byte -> release
    put_store(64'h0123_4567, 3'd0, 128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_115A, ACC_ORDERED, 0);
    push_exp(64'h0123_4567, 3'd0, 128'h5A, 2'd1);
    put_flush(0);

    // R7 R11 exclusive atomic 8+8, exclusive ordered 2
    put_store(64'h8000, 3'd3, 128'h0102030405060708, ACC_ATOMIC, 1);
    put_store(64'h8008, 3'd3, 128'h1112131415161718, ACC_ATOMIC, 1);
    push_exp(64'h8000, 3'd4, 128'h11121314151617180102030405060708, 2'd2);
    put_flush(1);
    put_store(64'h9000, 3'd1, 128'hBEEF, ACC_ORDERED, 1);
    push_exp(64'h9000, 3'd1, 128'hBEEF, 2'd3);
    put_flush(1);

    // R10 R3: random legal runs at unrelated addresses
    for (int it = 0; it < 60; it++) begin
      bit ex;
      logic [2:0] k;
      int tc, tot, held, c;
      logic [63:0] base;
      logic [127:0] acc, d;
      ex = ($urandom_range(0, 3) == 0);
      if (ex) k = $urandom_range(0, 1) ? ACC_ATOMIC : ACC_ORDERED;
      else    k = 3'($urandom_range(0, 3));
      tc = $urandom_range(0, 4);
      tot = 1 << tc;
      held = 0;
      base = {$urandom, $urandom};
      acc = '0;
      while (held < tot) begin
        c = $urandom_range(0, 4);
        while ((1 << c) > tot - held) c--;
        d = {$urandom, $urandom, $urandom, $urandom};
        put_store(base + 64'(held), 3'(c), d, k, ex);
        acc |= (d & bmask(c)) << (held * 8);
        held += 1 << c;
      end
      push_exp(base, 3'(tc), acc, wk_of(k, ex));
      put_flush(ex);
    end
    wait_idle();
    chk(err == 0, "R10 legal runs raise no error", err, 0);

    // R4 overflow past 16 bytes
    put_store(64'h2000, 3'd3, 128'hA1A2A3A4A5A6A7A8, ACC_NORMAL, 0);
    put_store(64'h2008, 3'd4, '1, ACC_NORMAL, 0);
    chk(err == 1, "R4 overflow flagged", err, 1);
    push_exp(64'h2000, 3'd3, 128'hA1A2A3A4A5A6A7A8, 2'd0);
    put_flush(0);
    do_reset();

    // R5 address gap leaves contents unchanged
    put_store(64'h3000, 3'd1, 128'h5566, ACC_STREAM, 0);
    put_store(64'h3003, 3'd0, 128'h77, ACC_STREAM, 0);
    chk(err == 1, "R5 gap flagged", err, 1);
    push_exp(64'h3000, 3'd1, 128'h5566, 2'd0);
    put_flush(0);
    do_reset();

    // R5 kind mismatch
    put_store(64'h3100, 3'd0, 128'h11, ACC_UNPRIV, 0);
    put_store(64'h3101, 3'd0, 128'h22, ACC_NORMAL, 0);
    chk(err == 1, "R5 kind mismatch flagged", err, 1);
    do_reset();

    // R5 exclusive flag mismatch
    put_store(64'h3200, 3'd0, 128'h11, ACC_ORDERED, 0);
    put_store(64'h3201, 3'd0, 128'h22, ACC_ORDERED, 1);
    chk(err == 1, "R5 exclusive mismatch flagged", err, 1);
    do_reset();

    // R5 illegal size code on an empty buffer, buffer stays empty
    put_store(64'h3300, 3'd5, '1, ACC_NORMAL, 0);
    chk(err == 1, "R5 size code flagged", err, 1);
    put_flush(0);
    chk(mem_valid == 0, "R5 nothing stored", mem_valid, 0);
    do_reset();

    // R6 three bytes held: flush refused, then completed to four
    put_store(64'h4000, 3'd0, 128'hC1, ACC_NORMAL, 0);
    put_store(64'h4001, 3'd1, 128'hC3C2, ACC_NORMAL, 0);
    put_flush(0);
    chk(err == 1, "R6 odd total flagged", err, 1);
    chk(mem_valid == 0, "R6 odd total not issued", mem_valid, 0);
    put_store(64'h4003, 3'd0, 128'hC4, ACC_NORMAL, 0);
    push_exp(64'h4000, 3'd2, 128'hC4C3C2C1, 2'd0);
    put_flush(0);
    do_reset();

    // R6 empty flush
    put_flush(0);
    chk(err == 1, "R6 empty flush flagged", err, 1);
    chk(mem_valid == 0, "R6 empty flush not issued", mem_valid, 0);
    do_reset();

    // R8 flag mismatch between run and flush
    put_store(64'h5000, 3'd2, 128'hDEADBEEF, ACC_ATOMIC, 1);
    put_flush(0);
    chk(err == 1, "R8 plain flush of exclusive run", err, 1);
    chk(mem_valid == 0, "R8 refused flush not issued", mem_valid, 0);
    push_exp(64'h5000, 3'd2, 128'hDEADBEEF, 2'd2);
    put_flush(1);
    do_reset();

    // R8 non-exclusive atomic run
    put_store(64'h5100, 3'd0, 128'h5, ACC_ATOMIC, 0);
    put_flush(0);
    chk(err == 1, "R8 plain atomic refused", err, 1);
    do_reset();

    // R8 exclusive normal run, then R13 stickiness
    put_store(64'h5200, 3'd0, 128'h6, ACC_NORMAL, 1);
    put_flush(1);
    chk(err == 1, "R8 exclusive normal refused", err, 1);
    repeat (5) @(negedge clk);
    chk(err == 1, "R13 error held", err, 1);
    do_reset();
    chk(err == 0, "R13 reset clears error", err, 0);

    // R12 flush and store offered together
    put_store(64'h6000, 3'd1, 128'hBEEF, ACC_NORMAL, 0);
    push_exp(64'h6000, 3'd1, 128'hBEEF, 2'd0);
    @(negedge clk);
    while (!fl_ready) @(negedge clk);
    st_addr = 64'h7000; st_size = 3'd0; st_data = 128'h77; st_kind = ACC_NORMAL; st_excl = 0;
    st_valid = 1; fl_excl = 0; fl_valid = 1;
    #1;
    chk(st_ready == 0, "R12 store held off by flush", st_ready, 0);
    @(negedge clk);
    fl_valid = 0;
    while (!st_ready) @(negedge clk);
    @(negedge clk);
    st_valid = 0;
    push_exp(64'h7000, 3'd0, 128'h77, 2'd0);
    put_flush(0);

    wait_idle();
    chk(err == 0, "R12 no error after priority case", err, 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule